// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches sixteen external lines and turns selected signal transitions on them into interrupt requests and event strobes. Each line can take its source from any of several input ports: a 4-bit port-select field per line picks which port supplies the pin whose index equals the line number. The pins are asynchronous to the block clock. They pass through a two-stage synchronizer, and after that each line compares the current level with the previous one to find rising and falling transitions.

Each line has an enable for rising transitions and an enable for falling transitions. Turning both on catches every change. A transition that is enabled and whose line has its interrupt mask set is latched into a sticky pending bit. The interrupt request for a line is its pending bit gated by its mask. Software clears a pending bit by writing 1 to it. On its own path, a transition on a line whose event mask is set produces a one-cycle event strobe and leaves the pending bit alone. All configuration goes through a small word-addressed register bus: synchronous writes, combinational reads.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous reset every mask, trigger enable, select field and pending bit reads 0, and `irq_o` and `evt_o` are 0.
- R2: Word addresses: 0 rising enables, 1 falling enables, 2 interrupt mask, 3 event mask, 4 pending, with line n at bit n. Addresses 8 to 11 are select registers, and line n uses register 8+n/4, bits 4*(n%4)+3 down to 4*(n%4). Written values read back, and unused addresses read 0.
- R3: Line n follows bit p*16+n of `port_pins_i`, where p is the line's select value. A select value of 4 or more gives a constant 0, and pin n of any other port has no effect.
- R4: A 0-to-1 change is detected only when the rising enable is 1, and a 1-to-0 change only when the falling enable is 1. With both enabled, both directions are detected.
- R5: A pin change driven before clock edge k shows in the pending register and on `irq_o` after edge k+2 and not earlier.
- R6: A detected transition sets the pending bit only while the line's interrupt mask is 1.
- R7: Writing 1 to a pending bit clears it and writing 0 leaves it. If a transition sets the bit on the same edge as a clear, the bit stays set.
- R8: `irq_o[n]` equals pending bit n AND interrupt mask n. Clearing the mask drops the request but keeps the pending bit.
- R9: With the event mask set, a transition gives a pulse on `evt_o[n]` for exactly one cycle, after the same edge as the pending update in R5. The pulse does not change the pending bit.
- R10: Changing a line's select value is never detected as a transition, even when the old and new sources differ in level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins_i | input | 64 | Asynchronous pins, port p pin n at bit p*16+n |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 16 | Per-line interrupt request |
| evt_o | output | 16 | Per-line one-cycle event strobe |

## Verification
A pin change driven at a falling clock edge passes through two synchronizer stages and then the pending/event registers. It is therefore due after the third rising edge. The bench samples at the falling edge after the second rising edge, where the result must still be absent, and again after the third, where it must be present. The event strobe is also checked one cycle later, when it must be gone. Register writes take effect at the rising edge they are presented to, and combinational reads are sampled 1 ns into the low phase. The pattern is swept over every line and port pairing, with a decoy on another port.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int SEL_W      = 4;
    localparam int FIELDS     = 4;
    localparam int REG_AW     = 4;
    localparam int SEL_BASE   = 8;

    localparam logic [REG_AW-1:0] ADR_RISE  = 4'd0;
    localparam logic [REG_AW-1:0] ADR_FALL  = 4'd1;
    localparam logic [REG_AW-1:0] ADR_IMASK = 4'd2;
    localparam logic [REG_AW-1:0] ADR_EMASK = 4'd3;
    localparam logic [REG_AW-1:0] ADR_PEND  = 4'd4;

    typedef struct packed {
        logic             imask;
        logic             emask;
        logic             rise_en;
        logic             fall_en;
        logic [SEL_W-1:0] sel;
    } line_cfg_t;

    function automatic logic [REG_AW-1:0] sel_addr(input int line);
        return REG_AW'(SEL_BASE + line / FIELDS);
    endfunction

    function automatic int sel_lsb(input int line);
        return SEL_W * (line % FIELDS);
    endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int NL = 16,
    parameter int DW = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_i,
    input  logic [REG_AW-1:0]     addr_i,
    input  logic [DW-1:0]         wdata_i,
    output logic [DW-1:0]         rdata_o,
    input  logic [NL-1:0]         pend_i,
    output line_cfg_t [NL-1:0]    cfg_o,
    output logic [NL-1:0]         clr_o
);
    logic [NL-1:0]             rise_q, fall_q, imask_q, emask_q;
    logic [NL-1:0][SEL_W-1:0]  sel_q;
    logic                      unused_hi;

    assign unused_hi = ^wdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q  <= '0;
            fall_q  <= '0;
            imask_q <= '0;
            emask_q <= '0;
            sel_q   <= '0;
        end else if (we_i) begin
            case (addr_i)
                ADR_RISE:  rise_q  <= wdata_i[NL-1:0];
                ADR_FALL:  fall_q  <= wdata_i[NL-1:0];
                ADR_IMASK: imask_q <= wdata_i[NL-1:0];
                ADR_EMASK: emask_q <= wdata_i[NL-1:0];
                default: begin
                    for (int i = 0; i < NL; i++) begin
                        if (addr_i == sel_addr(i))
                            sel_q[i] <= wdata_i[sel_lsb(i) +: SEL_W];
                    end
                end
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_RISE:  rdata_o[NL-1:0] = rise_q;
            ADR_FALL:  rdata_o[NL-1:0] = fall_q;
            ADR_IMASK: rdata_o[NL-1:0] = imask_q;
            ADR_EMASK: rdata_o[NL-1:0] = emask_q;
            ADR_PEND:  rdata_o[NL-1:0] = pend_i;
            default: begin
                for (int i = 0; i < NL; i++) begin
                    if (addr_i == sel_addr(i))
                        rdata_o[sel_lsb(i) +: SEL_W] = sel_q[i];
                end
            end
        endcase
    end

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            cfg_o[i].imask   = imask_q[i];
            cfg_o[i].emask   = emask_q[i];
            cfg_o[i].rise_en = rise_q[i];
            cfg_o[i].fall_en = fall_q[i];
            cfg_o[i].sel     = sel_q[i];
        end
    end

    assign clr_o = (we_i && addr_i == ADR_PEND) ? wdata_i[NL-1:0] : '0;

    // R2: an interrupt-mask write is visible in the register one edge later
    a_r2_imask_write: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == ADR_IMASK) |=> (imask_q == $past(wdata_i[NL-1:0])));
endmodule

// File: rtl/edge_irq_line.sv
module edge_irq_line
    import edge_irq_pkg::*;
#(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] pins_i,
    input  line_cfg_t     cfg_i,
    input  logic          clr_i,
    output logic          pend_o,
    output logic          irq_o,
    output logic          evt_o
);
    logic             cur;
    logic             prev_q;
    logic [SEL_W-1:0] sel_seen_q;
    logic             pend_q;
    logic             evt_q;
    logic             sel_stable;
    logic             rise_hit, fall_hit, hit;

    always_comb begin
        cur = 1'b0;
        for (int p = 0; p < NP; p++) begin
            if (cfg_i.sel == SEL_W'(p))
                cur = pins_i[p];
        end
    end

    assign sel_stable = (sel_seen_q == cfg_i.sel);
    assign rise_hit   = cur & ~prev_q & cfg_i.rise_en;
    assign fall_hit   = ~cur & prev_q & cfg_i.fall_en;
    assign hit        = (rise_hit | fall_hit) & sel_stable;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= 1'b0;
            sel_seen_q <= '0;
            pend_q     <= 1'b0;
            evt_q      <= 1'b0;
        end else begin
            prev_q     <= cur;
            sel_seen_q <= cfg_i.sel;
            evt_q      <= hit & cfg_i.emask;
            if (hit && cfg_i.imask)
                pend_q <= 1'b1;
            else if (clr_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q & cfg_i.imask;
    assign evt_o  = evt_q;

    // R6: a pending bit only rises when the mask was set on that edge
    a_r6_pend_needs_mask: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !$past(pend_q) && !$past(rst)) |-> $past(cfg_i.imask));

    // R9: an event strobe requires the event mask
    a_r9_evt_needs_emask: assert property (@(posedge clk) disable iff (rst)
        (evt_q && !$past(rst)) |-> $past(cfg_i.emask));

    // R7: a clear without a coincident masked transition empties the bit
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_i) && !$past(hit && cfg_i.imask) && !$past(rst)) |-> !pend_q);

    // R10: the cycle after a select change yields no strobe
    a_r10_sel_change_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (cfg_i.sel != $past(cfg_i.sel))) |=> !evt_q);
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins_i,
    input  logic                           bus_we_i,
    input  logic [REG_AW-1:0]              bus_addr_i,
    input  logic [DATA_W-1:0]              bus_wdata_i,
    output logic [DATA_W-1:0]              bus_rdata_o,
    output logic [NUM_LINES-1:0]           irq_o,
    output logic [NUM_LINES-1:0]           evt_o
);
    localparam int NPINS = NUM_PORTS * NUM_LINES;

    logic [NPINS-1:0]             pins_sync;
    line_cfg_t [NUM_LINES-1:0]    cfg;
    logic [NUM_LINES-1:0]         clr;
    logic [NUM_LINES-1:0]         pend;

    edge_irq_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (port_pins_i),
        .q_o (pins_sync)
    );

    edge_irq_regs #(.NL(NUM_LINES), .DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .pend_i  (pend),
        .cfg_o   (cfg),
        .clr_o   (clr)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        logic [NUM_PORTS-1:0] line_pins;
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign line_pins[p] = pins_sync[p*NUM_LINES + n];
        end
        edge_irq_line #(.NP(NUM_PORTS)) u_line (
            .clk    (clk),
            .rst    (rst),
            .pins_i (line_pins),
            .cfg_i  (cfg[n]),
            .clr_i  (clr[n]),
            .pend_o (pend[n]),
            .irq_o  (irq_o[n]),
            .evt_o  (evt_o[n])
        );
    end

    // R1: outputs are quiet right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == '0 && evt_o == '0));

    // R8: a request never stands without its pending bit
    a_r8_irq_has_pending: assert property (@(posedge clk) disable iff (rst)
        ((irq_o & ~pend) == '0));
endmodule

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP*NL-1:0] pins = '0;
    logic            we = 1'b0;
    logic [3:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NL-1:0]   irq, evt;

    int total = 0;
    int fails = 0;

    edge_irq_ctrl uut (
        .clk(clk), .rst(rst), .port_pins_i(pins),
        .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .evt_o(evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1: reset values
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 reg %0d", a), v, 32'h0);
        end
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 evt", 32'(evt), 32'h0);

        // R2: readback and unused addresses
        wr(4'd0, 32'h0000_A5A5); rd(4'd0, v); chk("R2 rise", v, 32'h0000_A5A5);
        wr(4'd1, 32'hFFFF_5A5A); rd(4'd1, v); chk("R2 fall", v, 32'h0000_5A5A);
        wr(4'd2, 32'h0000_1234); rd(4'd2, v); chk("R2 imask", v, 32'h0000_1234);
        wr(4'd3, 32'h0000_8001); rd(4'd3, v); chk("R2 emask", v, 32'h0000_8001);
        wr(4'd9, 32'hABCD_3210); rd(4'd9, v); chk("R2 sel1", v, 32'h0000_3210);
        rd(4'd6, v); chk("R2 unused", v, 32'h0);
        wr(4'd0, 0); wr(4'd1, 0); wr(4'd2, 0); wr(4'd3, 0); wr(4'd9, 0);
        cyc(4);

        // R3 R4 R5 R7: sweep every line and port with rising detection
        wr(4'd0, 32'hFFFF);
        wr(4'd2, 32'hFFFF);
        for (int n = 0; n < NL; n++) begin
            for (int p = 0; p < NP; p++) begin
                int decoy;
                decoy = (p + 1) % NP;
                wr(4'(8 + n/4), 32'(p) << (4*(n%4)));
                cyc(4);
                pins[decoy*NL + n] = 1'b1;
                cyc(4);
                rd(4'd4, v); chk($sformatf("R3 decoy n%0d p%0d", n, p), v, 32'h0);
                pins[p*NL + n] = 1'b1;
                cyc(2);
                rd(4'd4, v); chk($sformatf("R5 early n%0d p%0d", n, p), v, 32'h0);
                cyc(1);
                rd(4'd4, v); chk($sformatf("R4 rise n%0d p%0d", n, p), v, 32'(1) << n);
                chk($sformatf("R8 irq n%0d p%0d", n, p), 32'(irq), 32'(1) << n);
                wr(4'd4, 32'(1) << n);
                pins = '0;
                cyc(4);
                rd(4'd4, v); chk($sformatf("R7 clear n%0d p%0d", n, p), v, 32'h0);
            end
        end
        for (int r = 8; r < 12; r++) wr(4'(r), 0);

        // R4: falling only, then both
        wr(4'd0, 32'h0000); wr(4'd1, 32'h0008); cyc(2);
        pins[3] = 1'b1; cyc(4);
        rd(4'd4, v); chk("R4 fall ignores rise", v, 32'h0);
        pins[3] = 1'b0; cyc(3);
        rd(4'd4, v); chk("R4 fall detected", v, 32'h0008);
        wr(4'd4, 32'h0008);
        wr(4'd0, 32'h0008); cyc(2);
        pins[3] = 1'b1; cyc(3);
        rd(4'd4, v); chk("R4 both rise", v, 32'h0008);
        wr(4'd4, 32'h0008);
        pins[3] = 1'b0; cyc(3);
        rd(4'd4, v); chk("R4 both fall", v, 32'h0008);
        wr(4'd4, 32'h0008);

        // R6: unmasked line does not latch
        wr(4'd2, 32'hFFFF & ~32'h0001); wr(4'd0, 32'h0001); wr(4'd1, 0); cyc(2);
        pins[0] = 1'b1; cyc(4);
        rd(4'd4, v); chk("R6 masked pend", v, 32'h0);
        chk("R6 masked irq", 32'(irq), 32'h0);
        pins[0] = 1'b0; cyc(4);

        // R8: mask gates request, pending kept
        wr(4'd2, 32'h0002); wr(4'd0, 32'h0002); cyc(2);
        pins[1] = 1'b1; cyc(3);
        chk("R8 irq on", 32'(irq), 32'h0002);
        wr(4'd2, 32'h0000);
        chk("R8 irq masked", 32'(irq), 32'h0000);
        rd(4'd4, v); chk("R8 pend kept", v, 32'h0002);
        wr(4'd2, 32'h0002);
        chk("R8 irq back", 32'(irq), 32'h0002);
        wr(4'd4, 32'h0000);
        rd(4'd4, v); chk("R7 write0 keeps", v, 32'h0002);
        wr(4'd4, 32'h0002);
        pins[1] = 1'b0; cyc(4);

        // R7: transition on the clear edge wins
        wr(4'd2, 32'h0040); wr(4'd0, 32'h0040); wr(4'd1, 32'h0040); cyc(2);
        pins[6] = 1'b1; cyc(4);
        rd(4'd4, v); chk("R7 pre set", v, 32'h0040);
        pins[6] = 1'b0; cyc(2);
        wr(4'd4, 32'h0040);
        rd(4'd4, v); chk("R7 edge wins", v, 32'h0040);
        wr(4'd4, 32'h0040);
        rd(4'd4, v); chk("R7 cleared", v, 32'h0);

        // R9: event strobe, no pending
        wr(4'd2, 0); wr(4'd3, 32'h0010); wr(4'd0, 32'h0010); wr(4'd1, 0); cyc(2);
        pins[4] = 1'b1; cyc(2);
        chk("R9 evt early", 32'(evt), 32'h0);
        cyc(1);
        chk("R9 evt pulse", 32'(evt), 32'h0010);
        cyc(1);
        chk("R9 evt ends", 32'(evt), 32'h0);
        rd(4'd4, v); chk("R9 no pend", v, 32'h0);
        pins[4] = 1'b0; wr(4'd3, 0); cyc(4);

        // R10: select change is not an edge
        wr(4'd2, 32'h0020); wr(4'd0, 32'h0020); wr(4'd1, 32'h0020); wr(4'd3, 32'h0020);
        pins[5] = 1'b1; cyc(4);
        wr(4'd4, 32'h0020); cyc(1);
        wr(4'd9, 32'h0000_0010); cyc(4);
        rd(4'd4, v); chk("R10 sel to 1", v, 32'h0);
        wr(4'd9, 32'h0000_0000); cyc(4);
        rd(4'd4, v); chk("R10 sel to 0", v, 32'h0);
        pins[5] = 1'b0; cyc(3);
        rd(4'd4, v); chk("R10 live after", v, 32'h0020);
        wr(4'd4, 32'h0020); wr(4'd3, 0);

        // R3: select value beyond ports is constant 0
        wr(4'd2, 32'h0004); wr(4'd0, 32'h0004); wr(4'd1, 0);
        wr(4'd8, 32'h0000_0900); cyc(2);
        for (int p = 0; p < NP; p++) pins[p*NL + 2] = 1'b1;
        cyc(4);
        rd(4'd4, v); chk("R3 out of range", v, 32'h0);

        finish_up();
    end
endmodule